// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Protect Controller

This block owns the status byte of a serial EEPROM and decides, one command at a time, whether a memory-array write or a status-register write may start. A command front end sends single-cycle strobes for write-enable, write-disable, status write (with its data byte) and array write (with its target address). The block answers each status or array write with a one-cycle grant or deny pulse. A write timer reports the end of the timed write cycle with a done pulse.

The status byte holds two volatile flags and three bits that are treated as nonvolatile. The volatile flags are the write-enable latch and the write-busy flag. The nonvolatile bits are a status-lock bit and a two-bit protected-range selector. Software protection refuses array writes into the range that the selector names. Hardware protection applies when the status-lock bit is set and the active-low write-protect pin is low; it refuses status writes.

The nonvolatile bits are ordinary registers that only the power-on reset clears. A separate low-voltage detect input cancels any cycle in progress and clears the volatile flags.

Top module: `sr_wp_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status` reads 0x00 and all four grant/deny outputs are 0.
- R2: The `status` bit layout is: bit 7 status-lock, bits 6..4 always 0, bit 3 range-select high, bit 2 range-select low, bit 1 write-enable latch, bit 0 write-busy.
- R3: A `wren_stb` sets the write-enable latch, and a `wrdi_stb` clears it. Each change is visible in `status` on the cycle after the strobe.
- R4: A status or array write requested while the latch is 0, or while the busy flag is 1, gives a deny pulse one cycle after its strobe. It changes no state, and grant and deny are never both 1.
- R5: The range selector picks the protected words. 00 protects none. 01 protects the top quarter of the address space (0x6000–0x7FFF for 15 address bits). 10 protects the top half (0x4000–0x7FFF). 11 protects every address. An array write to a protected address is denied.
- R6: When the status-lock bit is 1 and `wp_n` is 0 at the status-write strobe, the status write is denied. In that state an array write outside the protected range is still granted if the latch is 1.
- R7: A granted write sets the busy flag on the cycle after its strobe and holds it until `write_done`. On that cycle's edge the busy flag and the latch both clear. A `write_done` while the busy flag is 0 has no effect.
- R8: While a status write is in progress, bits 7, 3 and 2 of `status` keep their old values. The new values appear together with the busy flag clearing.
- R9: A status write stores only bits 7, 3 and 2 of `wrsr_data`. All other bits of the byte are ignored.
- R10: A `lvd` cycle clears the latch and the busy flag on the next edge, cancels a pending status update, and keeps bits 7, 3 and 2. A later `write_done` then changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears every bit |
| lvd | input | 1 | Low-voltage detect, cancels the cycle and clears volatile flags |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| wrsr_stb | input | 1 | Status write command strobe |
| wrsr_data | input | 8 | Status byte offered with `wrsr_stb` |
| write_stb | input | 1 | Array write command strobe |
| write_addr | input | ADDR_W | Target word address of the array write |
| write_done | input | 1 | End of timed write cycle from the write timer |
| status | output | 8 | Status byte |
| write_grant | output | 1 | Array write accepted (one cycle) |
| write_deny | output | 1 | Array write refused (one cycle) |
| wrsr_grant | output | 1 | Status write accepted (one cycle) |
| wrsr_deny | output | 1 | Status write refused (one cycle) |

## Verification
Every result of this block is due exactly one clock edge after its cause. Grant and deny pulses, the busy flag rising, latch changes, completion clearing, and the status-lock and range bits taking their new values all follow this rule. The bench drives each strobe on a falling edge and removes it on the next falling edge. Between those two edges lies the single rising edge that registers the result, so it samples the outputs on that second falling edge. The bench keeps its own model of the five status bits. It predicts protection from the top two address bits compared against the selector, rather than the magnitude compare the design uses. It then sweeps every selector value, both pin levels and a spread of addresses including each range boundary.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef struct packed {
    logic lock;
    logic rsel1;
    logic rsel0;
  } nv_bits_t;

  localparam nv_bits_t NV_CLEAR = '{lock: 1'b0, rsel1: 1'b0, rsel0: 1'b0};

  function automatic logic [7:0] pack_status(input nv_bits_t nv, input logic wel, input logic wip);
    return {nv.lock, 3'b000, nv.rsel1, nv.rsel0, wel, wip};
  endfunction

  function automatic nv_bits_t take_nv(input logic [7:0] din);
    nv_bits_t r;
    r.lock  = din[7];
    r.rsel1 = din[3];
    r.rsel0 = din[2];
    return r;
  endfunction

endpackage

// File: rtl/sr_guard.sv
module sr_guard
  import sr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              wel,
  input  logic              wip,
  input  nv_bits_t          nv,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              blk_hit,
  output logic              hw_lock,
  output logic              array_ok,
  output logic              status_ok
);
  localparam logic [ADDR_W-1:0] SPAN      = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] HALF_BASE = (SPAN >> 1) + 1'b1;
  localparam logic [ADDR_W-1:0] QTR_BASE  = HALF_BASE + (HALF_BASE >> 1);

  function automatic logic range_hit(input logic [1:0] sel, input logic [ADDR_W-1:0] a);
    case (sel)
      2'b00:   return 1'b0;
      2'b01:   return a >= QTR_BASE;
      2'b10:   return a >= HALF_BASE;
      default: return 1'b1;
    endcase
  endfunction

  logic ready;

  always_comb begin
    ready     = wel && !wip;
    blk_hit   = range_hit({nv.rsel1, nv.rsel0}, addr);
    hw_lock   = nv.lock && !wp_n;
    array_ok  = ready && !blk_hit;
    status_ok = ready && !hw_lock;
  end
endmodule

// File: rtl/sr_volatile.sv
module sr_volatile (
  input  logic clk,
  input  logic rst_n,
  input  logic lvd,
  input  logic set_wel,
  input  logic clr_wel,
  input  logic start,
  input  logic finish,
  output logic wel,
  output logic wip
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
      wip <= 1'b0;
    end else if (lvd || finish) begin
      wel <= 1'b0;
      wip <= 1'b0;
    end else begin
      if (start) wip <= 1'b1;
      if (clr_wel) wel <= 1'b0;
      else if (set_wel) wel <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_nv_store.sv
module sr_nv_store
  import sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvd,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       finish,
  output nv_bits_t   nv,
  output logic       pend
);
  nv_bits_t pend_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv       <= NV_CLEAR;
      pend_val <= NV_CLEAR;
      pend     <= 1'b0;
    end else if (lvd) begin
      pend <= 1'b0;
    end else if (finish) begin
      if (pend) nv <= pend_val;
      pend <= 1'b0;
    end else if (load) begin
      pend_val <= take_nv(din);
      pend     <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_wp_ctrl.sv
module sr_wp_ctrl
  import sr_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvd,
  input  logic              wp_n,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              wrsr_stb,
  input  logic [7:0]        wrsr_data,
  input  logic              write_stb,
  input  logic [ADDR_W-1:0] write_addr,
  input  logic              write_done,
  output logic [7:0]        status,
  output logic              write_grant,
  output logic              write_deny,
  output logic              wrsr_grant,
  output logic              wrsr_deny
);
  logic     wel, wip, pend;
  nv_bits_t nv;
  logic     blk_hit, hw_lock, array_ok, status_ok;
  logic     arr_start, st_start, any_start, finish;

  sr_guard #(.ADDR_W(ADDR_W)) u_guard (
    .wel(wel), .wip(wip), .nv(nv), .wp_n(wp_n), .addr(write_addr),
    .blk_hit(blk_hit), .hw_lock(hw_lock),
    .array_ok(array_ok), .status_ok(status_ok)
  );

  assign arr_start = write_stb && array_ok && !lvd;
  assign st_start  = wrsr_stb && !write_stb && status_ok && !lvd;
  assign any_start = arr_start || st_start;
  assign finish    = write_done && wip;

  sr_volatile u_vol (
    .clk(clk), .rst_n(rst_n), .lvd(lvd),
    .set_wel(wren_stb), .clr_wel(wrdi_stb),
    .start(any_start), .finish(finish),
    .wel(wel), .wip(wip)
  );

  sr_nv_store u_nv (
    .clk(clk), .rst_n(rst_n), .lvd(lvd),
    .load(st_start), .din(wrsr_data), .finish(finish),
    .nv(nv), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_grant <= 1'b0;
      write_deny  <= 1'b0;
      wrsr_grant  <= 1'b0;
      wrsr_deny   <= 1'b0;
    end else begin
      write_grant <= arr_start;
      write_deny  <= write_stb && !arr_start;
      wrsr_grant  <= st_start;
      wrsr_deny   <= wrsr_stb && !write_stb && !st_start;
    end
  end

  assign status = pack_status(nv, wel, wip);
endmodule

// File: rtl/sr_wp_ctrl_chk.sv
module sr_wp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lvd,
  input logic       wp_n,
  input logic       write_done,
  input logic [7:0] status,
  input logic       write_grant,
  input logic       write_deny,
  input logic       wrsr_grant,
  input logic       wrsr_deny,
  input logic       blk_hit
);
  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (write_grant || wrsr_grant) |-> ($past(status[1]) && !$past(status[0]))); // R4

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_grant && write_deny) && !(wrsr_grant && wrsr_deny)); // R4

  AST_PROT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    write_grant |-> !$past(blk_hit)); // R5

  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_grant |-> !($past(status[7]) && !$past(wp_n))); // R6

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (write_grant || wrsr_grant) |-> status[0]); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (write_done && status[0]) |=> (status[1:0] == 2'b00)); // R7

  AST_NV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> (status[7:2] == $past(status[7:2]))); // R8

  AST_LVD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lvd |=> (status[1:0] == 2'b00)); // R10
endmodule

bind sr_wp_ctrl sr_wp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lvd(lvd), .wp_n(wp_n), .write_done(write_done),
  .status(status), .write_grant(write_grant), .write_deny(write_deny),
  .wrsr_grant(wrsr_grant), .wrsr_deny(wrsr_deny), .blk_hit(blk_hit)
);

// File: tb/sr_wp_ctrl_tb.sv
`timescale 1ns/1ps
module sr_wp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvd = 1'b0, wp_n = 1'b1;
  logic        wren_stb = 1'b0, wrdi_stb = 1'b0, wrsr_stb = 1'b0, write_stb = 1'b0;
  logic [7:0]  wrsr_data = 8'h00;
  logic [14:0] write_addr = '0;
  logic        write_done = 1'b0;
  logic [7:0]  status;
  logic        write_grant, write_deny, wrsr_grant, wrsr_deny;

  int total = 0;
  int bad = 0;
  logic       m_wel = 0, m_wip = 0, m_pend = 0;
  logic [2:0] m_nv = 3'b000, m_pv = 3'b000;

  always #2.5 clk = ~clk;

  sr_wp_ctrl #(.ADDR_W(15)) u_dut (
    .clk(clk), .rst_n(rst_n), .lvd(lvd), .wp_n(wp_n),
    .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb),
    .wrsr_data(wrsr_data), .write_stb(write_stb), .write_addr(write_addr),
    .write_done(write_done), .status(status),
    .write_grant(write_grant), .write_deny(write_deny),
    .wrsr_grant(wrsr_grant), .wrsr_deny(wrsr_deny)
  );

  function automatic logic [7:0] exp_status();
    return {m_nv[2], 3'b000, m_nv[1], m_nv[0], m_wel, m_wip};
  endfunction

  function automatic logic hit(input logic [1:0] sel, input logic [14:0] a);
    logic [1:0] t = a[14:13];
    return (sel == 2'd3) || (sel == 2'd2 && t[1]) || (sel == 2'd1 && t == 2'b11);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wren();
    @(negedge clk) wren_stb = 1'b1;
    @(negedge clk) wren_stb = 1'b0;
    m_wel = 1'b1;
    check("R3 wren", status, exp_status());
  endtask

  task automatic do_wrdi();
    @(negedge clk) wrdi_stb = 1'b1;
    @(negedge clk) wrdi_stb = 1'b0;
    m_wel = 1'b0;
    check("R3 wrdi", status, exp_status());
  endtask

  task automatic do_write(input logic [14:0] a, input string tag);
    logic ok;
    ok = m_wel && !m_wip && !hit(m_nv[1:0], a);
    @(negedge clk) begin write_stb = 1'b1; write_addr = a; end
    @(negedge clk) write_stb = 1'b0;
    if (ok) m_wip = 1'b1;
    check(tag, {6'd0, write_grant, write_deny}, {6'd0, ok, !ok});
    check("R7 busy after write", status, exp_status());
  endtask

  task automatic do_wrsr(input logic [7:0] d, input string tag);
    logic ok;
    ok = m_wel && !m_wip && !(m_nv[2] && !wp_n);
    @(negedge clk) begin wrsr_stb = 1'b1; wrsr_data = d; end
    @(negedge clk) wrsr_stb = 1'b0;
    if (ok) begin m_wip = 1'b1; m_pend = 1'b1; m_pv = {d[7], d[3], d[2]}; end
    check(tag, {6'd0, wrsr_grant, wrsr_deny}, {6'd0, ok, !ok});
    check("R8 old bits during cycle", status, exp_status());
  endtask

  task automatic do_done(input string tag);
    @(negedge clk) write_done = 1'b1;
    @(negedge clk) write_done = 1'b0;
    if (m_wip) begin
      m_wip = 1'b0; m_wel = 1'b0;
      if (m_pend) m_nv = m_pv;
      m_pend = 1'b0;
    end
    check(tag, status, exp_status());
  endtask

  task automatic set_nv(input logic [2:0] v);
    wp_n = 1'b1;
    do_wren();
    do_wrsr({v[2], 3'b000, v[1], v[0], 2'b00}, "R9 setup wrsr");
    do_done("R8 new bits at done");
  endtask

  function automatic logic [14:0] pick_addr(input int i);
    if (i < 32) return 15'(i * 1024 + (i % 7) * 13);
    case (i)
      32: return 15'h3FFF;
      33: return 15'h4000;
      34: return 15'h5FFF;
      35: return 15'h6000;
      default: return 15'h7FFF;
    endcase
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status in reset", status, 8'h00);
    check("R1 pulses in reset", {4'd0, write_grant, write_deny, wrsr_grant, wrsr_deny}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status, 8'h00);

    do_write(15'h0100, "R4 write without latch");
    do_wrsr(8'h8C, "R4 wrsr without latch");
    do_wren();
    check("R2 latch in bit1", status, 8'h02);
    do_wrdi();
    do_wren();

    do_write(15'h1234, "R7 write granted");
    check("R7 busy bit0", status, 8'h03);
    do_write(15'h0010, "R4 write while busy");
    do_wrsr(8'h00, "R4 wrsr while busy");
    do_done("R7 done clears busy and latch");
    do_wren();
    do_done("R7 idle done ignored");
    check("R7 latch kept", status, 8'h02);

    do_wrsr(8'hFF, "R9 wrsr all ones");
    check("R8 old bits shown", status, 8'h03);
    do_done("R9 only 7/3/2 stored");
    check("R2 R9 status layout", status, 8'h8C);

    set_nv(3'b101);
    wp_n = 1'b0;
    do_wren();
    do_wrsr(8'h00, "R6 wrsr hw-locked");
    check("R6 bits unchanged", status, 8'h86);
    do_write(15'h1000, "R6 write outside range under lock");
    do_done("R6 done");
    do_wren();
    do_write(15'h7000, "R6 R5 write inside range under lock");
    do_wrdi();

    for (int s = 0; s < 4; s++) begin
      set_nv({s[0], s[1:0]});
      for (int p = 0; p < 2; p++) begin
        wp_n = p[0];
        for (int i = 0; i < 37; i++) begin
          do_wren();
          do_write(pick_addr(i), "R5 range sweep");
          if (m_wip) do_done("R7 sweep done");
        end
        do_wren();
        do_wrsr({s[0], 3'b000, s[1:0], 2'b00}, "R6 sweep wrsr");
        if (m_wip) do_done("R8 sweep done");
      end
    end

    set_nv(3'b000);
    do_wren();
    do_wrsr(8'h88, "R10 wrsr before lvd");
    @(negedge clk) lvd = 1'b1;
    @(negedge clk) lvd = 1'b0;
    m_wel = 1'b0; m_wip = 1'b0; m_pend = 1'b0;
    check("R10 lvd clears volatile", status, 8'h00);
    do_done("R10 done after lvd ignored");
    check("R10 bits kept", status, 8'h00);
    do_wren();
    check("R10 latch usable again", status, 8'h02);

    set_nv(3'b111);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 power-on clears all", status, 8'h00);
    rst_n = 1'b1;
    m_wel = 0; m_wip = 0; m_nv = 3'b000; m_pend = 0;
    @(negedge clk);
    finish_run();
  end
endmodule